// File: doc/BRIEF.md
# Reciprocal Pre-Scaling Fixup for Single-Precision Division

This block prepares an IEEE-754 single-precision division before an iterative reciprocal stage runs. Each cycle it may accept one numerator and one denominator word. It sorts the pair into one of several special cases or the ordinary path. For a special case it replaces the numerator, the denominator and the result seed with fixed words, and it may raise an invalid-operation or divide-by-zero pulse. For ordinary operands it multiplies the two operands by powers of two. A later refinement stage then avoids intermediate overflow and underflow. An 8-bit adjust code tells that stage which correction it must undo.

The outputs are registered once. A result appears on the cycle after its operands were presented with `in_valid`. The substituted default NaN is the all-ones word. The constant 1.0 is `0x3F800000`. Bit 22 of a NaN is its quiet bit.

Top module: `recip_prescale`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid`. After reset every output is zero. `invalid_o` and `divzero_o` are single-cycle pulses and stay low whenever `out_valid` is low.
- R2: If either operand is a NaN (exponent all ones, nonzero fraction), all three word outputs become `0xFFFFFFFF`. This case has the highest priority. `invalid_o` rises when the NaN operand has bit 22 clear. When both operands are NaN, `invalid_o` rises unless bit 22 is set in both.
- R3: Infinity divided by infinity, and zero divided by zero, give `0xFFFFFFFF` on all three word outputs and raise `invalid_o`. Either sign is accepted.
- R4: A non-NaN, nonzero numerator over a zero denominator makes the numerator an infinity whose sign is the XOR of the operand signs. The denominator and the seed become 1.0. `divzero_o` rises only when the numerator was not infinite.
- R5: A finite numerator over an infinite denominator, or a zero numerator over a finite nonzero denominator, makes the numerator a zero with the XOR sign. The denominator and the seed become 1.0.
- R6: An infinite numerator over a finite nonzero denominator makes the numerator an infinity with the XOR sign. The denominator and the seed become 1.0.
- R7: On the ordinary path, `normal_o` is 1 and the seed is 0. In every special case, `normal_o` is 0 and the adjust code is 0.
- R8: With raw exponent fields `ne` and `nd`, the case `ne - nd + 127 <= 23` takes priority over the others. It gives adjust code `0x80`, multiplies the numerator by 2^64 and multiplies the denominator by 2^-64.
- R9: Otherwise, if `ne - nd + 127 > 230`, the adjust code is `0x40`, the numerator is multiplied by 2^-32 and the denominator by 2^32.
- R10: Otherwise, if `ne <= 25`, both operands are multiplied by 2^64 and the adjust code is 0.
- R11: Otherwise, if `nd <= 1`, both operands are multiplied by 2^32. Failing that, if `nd > 252`, both are multiplied by 2^-32. The adjust code is 0 in both cases. Operands in no window pass through unchanged.
- R12: Scaling a subnormal operand first normalizes its significand, so the result is the exact power-of-two multiple with a normal exponent. Signs are preserved by all scaling.
- R13: `invalid_o` and `divzero_o` never rise together, and neither rises on the ordinary path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| num_i | input | 32 | Numerator, single-precision |
| den_i | input | 32 | Denominator, single-precision |
| out_valid | output | 1 | Result words valid this cycle |
| num_o | output | 32 | Adjusted or substituted numerator |
| den_o | output | 32 | Adjusted or substituted denominator |
| seed_o | output | 32 | Seed result word |
| adj_o | output | 8 | Adjust code: 0x80, 0x40 or 0 |
| normal_o | output | 1 | Ordinary path taken |
| invalid_o | output | 1 | Invalid-operation pulse |
| divzero_o | output | 1 | Divide-by-zero pulse |

## Verification
The properties assume that reset is held for at least one clock before the first operand. They also assume the operand words are stable across the sampling edge whenever `in_valid` is high. Any 32-bit pattern is a legal operand, so the properties make no claim on operand values. The bench drives each operand pair on a falling edge and holds it for one full cycle. It then drops `in_valid` so that every result is followed by an idle cycle, in which the exception pulses must already be low. Vectors are chosen at the exact window boundaries, at each rung of the priority ladder and on subnormal inputs.

// File: rtl/rps_pkg.sv
package rps_pkg;

    localparam int WORD_W  = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int BIAS    = 127;
    localparam int EXP_TOP = (1 << EXP_W) - 2;
    localparam int EXP_INF = (1 << EXP_W) - 1;
    localparam int ADJ_W   = 8;

    // exponent window limits
    localparam int W_LOW_LIM   = FRAC_W;
    localparam int W_HIGH_LIM  = EXP_TOP - SIG_W;
    localparam int N_SMALL_LIM = FRAC_W + 2;
    localparam int D_TINY_LIM  = 1;
    localparam int D_HUGE_LIM  = EXP_TOP - 2;

    localparam logic [WORD_W-1:0] DEF_NAN  = '1;
    localparam logic [WORD_W-1:0] ONE_WORD = 32'h3F80_0000;
    localparam logic [ADJ_W-1:0]  ADJ_LOWQ = 8'h80;
    localparam logic [ADJ_W-1:0]  ADJ_HIGHQ = 8'h40;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } f32_t;

    typedef enum logic [2:0] {
        SC_NONE, SC_UP32, SC_UP64, SC_DN32, SC_DN64
    } scale_e;

    typedef struct packed {
        logic [WORD_W-1:0] num;
        logic [WORD_W-1:0] den;
        logic [WORD_W-1:0] seed;
        logic [ADJ_W-1:0]  adj;
        logic              normal;
        logic              inv;
        logic              dz;
    } fix_t;

    function automatic logic is_nan(input f32_t x);
        return (x.exp == EXP_W'(EXP_INF)) && (x.frac != '0);
    endfunction

    function automatic logic is_inf(input f32_t x);
        return (x.exp == EXP_W'(EXP_INF)) && (x.frac == '0);
    endfunction

    function automatic logic is_zero(input f32_t x);
        return (x.exp == '0) && (x.frac == '0);
    endfunction

    function automatic f32_t signed_inf(input logic s);
        f32_t r;
        r.sign = s;
        r.exp  = '1;
        r.frac = '0;
        return r;
    endfunction

    function automatic f32_t signed_zero(input logic s);
        f32_t r;
        r      = '0;
        r.sign = s;
        return r;
    endfunction

    // leading zeros of a fraction field (FRAC_W when empty)
    function automatic int lead_zeros(input logic [FRAC_W-1:0] f);
        int n;
        n = FRAC_W;
        for (int i = 0; i < FRAC_W; i++) begin
            if (f[i]) n = FRAC_W - 1 - i;
        end
        return n;
    endfunction

    function automatic int scale_amount(input scale_e s);
        case (s)
            SC_UP32: return 32;
            SC_UP64: return 64;
            SC_DN32: return -32;
            SC_DN64: return -64;
            default: return 0;
        endcase
    endfunction

    // multiply by 2^k with normalization and round-to-nearest-even on underflow
    function automatic f32_t scale_pow2(input f32_t x, input int k);
        logic [SIG_W-1:0]        m;
        logic [2*SIG_W:0]        ext;
        logic [WORD_W-2:0]       mag;
        logic                    g;
        logic                    st;
        int                      e;
        int                      lz;
        int                      sh;
        f32_t                    r;
        if (is_zero(x) || (x.exp == EXP_W'(EXP_INF))) return x;
        if (x.exp == '0) begin
            lz = lead_zeros(x.frac);
            m  = {1'b0, x.frac} << (lz + 1);
            e  = -lz;
        end else begin
            m = {1'b1, x.frac};
            e = int'(x.exp);
        end
        e = e + k;
        if (e >= EXP_INF) begin
            mag = {EXP_W'(EXP_INF), FRAC_W'(0)};
        end else if (e >= 1) begin
            mag = {e[EXP_W-1:0], m[FRAC_W-1:0]};
        end else begin
            sh = 1 - e;
            if (sh > SIG_W + 1) begin
                mag = '0;
            end else begin
                ext = {m, (SIG_W+1)'(0)} >> sh;
                g   = ext[SIG_W];
                st  = |ext[SIG_W-1:0];
                mag = {EXP_W'(0), ext[2*SIG_W-1:SIG_W+1]}
                    + (WORD_W-1)'(g & (st | ext[SIG_W+1]));
            end
        end
        r = {x.sign, mag};
        return r;
    endfunction

endpackage

// File: rtl/rps_classify.sv
module rps_classify
    import rps_pkg::*;
(
    input  f32_t a,
    input  f32_t b,
    output logic special,
    output fix_t fix
);
    logic xs;
    logic na, nb, ia, ib, za, zb;

    assign xs = a.sign ^ b.sign;
    assign na = is_nan(a);
    assign nb = is_nan(b);
    assign ia = is_inf(a);
    assign ib = is_inf(b);
    assign za = is_zero(a);
    assign zb = is_zero(b);

    always_comb begin
        fix.num    = a;
        fix.den    = b;
        fix.seed   = ONE_WORD;
        fix.adj    = '0;
        fix.normal = 1'b0;
        fix.inv    = 1'b0;
        fix.dz     = 1'b0;
        special    = 1'b1;
        if (na || nb) begin
            fix.num  = DEF_NAN;
            fix.den  = DEF_NAN;
            fix.seed = DEF_NAN;
            if (na && nb)  fix.inv = ~(a.frac[FRAC_W-1] & b.frac[FRAC_W-1]);
            else if (na)   fix.inv = ~a.frac[FRAC_W-1];
            else           fix.inv = ~b.frac[FRAC_W-1];
        end else if ((ia && ib) || (za && zb)) begin
            fix.num  = DEF_NAN;
            fix.den  = DEF_NAN;
            fix.seed = DEF_NAN;
            fix.inv  = 1'b1;
        end else if (zb) begin
            fix.num = signed_inf(xs);
            fix.den = ONE_WORD;
            fix.dz  = ~ia;
        end else if (ib || za) begin
            fix.num = signed_zero(xs);
            fix.den = ONE_WORD;
        end else if (ia) begin
            fix.num = signed_inf(xs);
            fix.den = ONE_WORD;
        end else begin
            special = 1'b0;
        end
    end
endmodule

// File: rtl/rps_window.sv
module rps_window
    import rps_pkg::*;
(
    input  f32_t             a,
    input  f32_t             b,
    output scale_e           sel_num,
    output scale_e           sel_den,
    output logic [ADJ_W-1:0] adj
);
    int ne, nd, dq;

    always_comb begin
        ne      = int'(a.exp);
        nd      = int'(b.exp);
        dq      = ne - nd + BIAS;
        sel_num = SC_NONE;
        sel_den = SC_NONE;
        adj     = '0;
        if (dq <= W_LOW_LIM) begin
            adj     = ADJ_LOWQ;
            sel_num = SC_UP64;
            sel_den = SC_DN64;
        end else if (dq > W_HIGH_LIM) begin
            adj     = ADJ_HIGHQ;
            sel_num = SC_DN32;
            sel_den = SC_UP32;
        end else if (ne <= N_SMALL_LIM) begin
            sel_num = SC_UP64;
            sel_den = SC_UP64;
        end else if (nd <= D_TINY_LIM) begin
            sel_num = SC_UP32;
            sel_den = SC_UP32;
        end else if (nd > D_HUGE_LIM) begin
            sel_num = SC_DN32;
            sel_den = SC_DN32;
        end
    end
endmodule

// File: rtl/rps_scale.sv
module rps_scale
    import rps_pkg::*;
(
    input  f32_t   x,
    input  scale_e sel,
    output f32_t   y
);
    assign y = scale_pow2(x, scale_amount(sel));
endmodule

// File: rtl/recip_prescale.sv
module recip_prescale
    import rps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] num_i,
    input  logic [WORD_W-1:0] den_i,
    output logic              out_valid,
    output logic [WORD_W-1:0] num_o,
    output logic [WORD_W-1:0] den_o,
    output logic [WORD_W-1:0] seed_o,
    output logic [ADJ_W-1:0]  adj_o,
    output logic              normal_o,
    output logic              invalid_o,
    output logic              divzero_o
);
    localparam int N_OPS = 2;

    f32_t             ops    [N_OPS];
    f32_t             scaled [N_OPS];
    scale_e           sels   [N_OPS];
    fix_t             spec_fix;
    fix_t             nxt;
    fix_t             q;
    logic             special;
    logic [ADJ_W-1:0] win_adj;
    logic             vld_q;

    assign ops[0] = num_i;
    assign ops[1] = den_i;

    rps_classify u_cls (
        .a       (ops[0]),
        .b       (ops[1]),
        .special (special),
        .fix     (spec_fix)
    );

    rps_window u_win (
        .a       (ops[0]),
        .b       (ops[1]),
        .sel_num (sels[0]),
        .sel_den (sels[1]),
        .adj     (win_adj)
    );

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_scale
        rps_scale u_scl (
            .x   (ops[gi]),
            .sel (sels[gi]),
            .y   (scaled[gi])
        );
    end

    always_comb begin
        if (special) begin
            nxt = spec_fix;
        end else begin
            nxt.num    = scaled[0];
            nxt.den    = scaled[1];
            nxt.seed   = '0;
            nxt.adj    = win_adj;
            nxt.normal = 1'b1;
            nxt.inv    = 1'b0;
            nxt.dz     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                q <= nxt;
            end else begin
                q.inv <= 1'b0;
                q.dz  <= 1'b0;
            end
        end
    end

    assign out_valid = vld_q;
    assign num_o     = q.num;
    assign den_o     = q.den;
    assign seed_o    = q.seed;
    assign adj_o     = q.adj;
    assign normal_o  = q.normal;
    assign invalid_o = q.inv;
    assign divzero_o = q.dz;
endmodule

// File: rtl/recip_prescale_chk.sv
module recip_prescale_chk
    import rps_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [WORD_W-1:0] num_o,
    input logic [WORD_W-1:0] den_o,
    input logic [WORD_W-1:0] seed_o,
    input logic [ADJ_W-1:0]  adj_o,
    input logic              normal_o,
    input logic              invalid_o,
    input logic              divzero_o
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_PULSE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!invalid_o && !divzero_o)); // R1
    AST_INVALID_NAN: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> (num_o == DEF_NAN && den_o == DEF_NAN && seed_o == DEF_NAN)); // R3
    AST_DIVZERO_INF: assert property (@(posedge clk) disable iff (rst)
        divzero_o |-> (num_o[WORD_W-2:0] == 31'h7F80_0000 && den_o == ONE_WORD)); // R4
    AST_NORMAL_SEED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && normal_o) |-> (seed_o == '0)); // R7
    AST_SPECIAL_NOADJ: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !normal_o) |-> (adj_o == '0)); // R7
    AST_ADJ_CODE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($onehot0(adj_o) && (adj_o & 8'h3F) == '0)); // R8
    AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(invalid_o && divzero_o)); // R13
    AST_NORMAL_NOEXC: assert property (@(posedge clk) disable iff (rst)
        (out_valid && normal_o) |-> (!invalid_o && !divzero_o)); // R13
endmodule

bind recip_prescale recip_prescale_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .num_o     (num_o),
    .den_o     (den_o),
    .seed_o    (seed_o),
    .adj_o     (adj_o),
    .normal_o  (normal_o),
    .invalid_o (invalid_o),
    .divzero_o (divzero_o)
);

// File: tb/tb_recip_prescale.sv
module tb_recip_prescale;
    localparam logic [31:0] NAN = 32'hFFFF_FFFF;
    localparam logic [31:0] ONE = 32'h3F80_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] num_i = '0;
    logic [31:0] den_i = '0;
    logic        out_valid;
    logic [31:0] num_o, den_o, seed_o;
    logic [7:0]  adj_o;
    logic        normal_o, invalid_o, divzero_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    recip_prescale dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .num_i(num_i), .den_i(den_i),
        .out_valid(out_valid), .num_o(num_o), .den_o(den_o), .seed_o(seed_o),
        .adj_o(adj_o), .normal_o(normal_o), .invalid_o(invalid_o), .divzero_o(divzero_o)
    );

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // apply one pair, check all outputs on the cycle after, then an idle cycle
    task automatic vec(input string req, input logic [31:0] n, input logic [31:0] d,
                       input logic [31:0] en, input logic [31:0] ed, input logic [31:0] es,
                       input logic [7:0] ea, input logic enrm, input logic einv, input logic edz);
        @(negedge clk);
        num_i = n; den_i = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n_checks++;
        if (out_valid !== 1'b1 || num_o !== en || den_o !== ed || seed_o !== es ||
            adj_o !== ea || normal_o !== enrm || invalid_o !== einv || divzero_o !== edz) begin
            n_fail++;
            $display("FAIL %s: actual v=%b n=%h d=%h s=%h a=%h nrm=%b inv=%b dz=%b expected v=1 n=%h d=%h s=%h a=%h nrm=%b inv=%b dz=%b",
                     req, out_valid, num_o, den_o, seed_o, adj_o, normal_o, invalid_o, divzero_o,
                     en, ed, es, ea, enrm, einv, edz);
        end
        @(negedge clk);
        chk_bit({req, " R1 idle valid"}, out_valid, 1'b0);
        chk_bit({req, " R1 idle pulses"}, invalid_o | divzero_o, 1'b0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || num_o !== '0 || den_o !== '0 || seed_o !== '0 ||
            adj_o !== '0 || normal_o !== 1'b0 || invalid_o !== 1'b0 || divzero_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: actual v=%b n=%h d=%h s=%h a=%h expected all zero",
                     out_valid, num_o, den_o, seed_o, adj_o);
        end
    endtask

    task automatic t_nan;
        vec("R2 qnan num",      32'h7FC0_0000, ONE,           NAN, NAN, NAN, 8'h00, 0, 0, 0);
        vec("R2 snan num",      32'h7F80_0001, ONE,           NAN, NAN, NAN, 8'h00, 0, 1, 0);
        vec("R2 snan den",      32'h4000_0000, 32'h7FA0_0000, NAN, NAN, NAN, 8'h00, 0, 1, 0);
        vec("R2 both quiet",    32'h7FC0_0000, 32'hFFC0_0000, NAN, NAN, NAN, 8'h00, 0, 0, 0);
        vec("R2 quiet+signal",  32'h7FC0_0000, 32'h7F80_0010, NAN, NAN, NAN, 8'h00, 0, 1, 0);
        vec("R2 nan over zero", 32'h7FC0_0000, 32'h0000_0000, NAN, NAN, NAN, 8'h00, 0, 0, 0);
    endtask

    task automatic t_invalid_ops;
        vec("R3 inf/inf",   32'h7F80_0000, 32'hFF80_0000, NAN, NAN, NAN, 8'h00, 0, 1, 0);
        vec("R3 zero/zero", 32'h8000_0000, 32'h0000_0000, NAN, NAN, NAN, 8'h00, 0, 1, 0);
    endtask

    task automatic t_divzero;
        vec("R4 3/-0",   32'h4040_0000, 32'h8000_0000, 32'hFF80_0000, ONE, ONE, 8'h00, 0, 0, 1);
        vec("R4 inf/0",  32'h7F80_0000, 32'h0000_0000, 32'h7F80_0000, ONE, ONE, 8'h00, 0, 0, 0);
        vec("R4 sub/0",  32'h0000_0001, 32'h0000_0000, 32'h7F80_0000, ONE, ONE, 8'h00, 0, 0, 1);
    endtask

    task automatic t_zero_inf;
        vec("R5 5/-inf",  32'h40A0_0000, 32'hFF80_0000, 32'h8000_0000, ONE, ONE, 8'h00, 0, 0, 0);
        vec("R5 -0/2",    32'h8000_0000, 32'h4000_0000, 32'h8000_0000, ONE, ONE, 8'h00, 0, 0, 0);
        vec("R5 0/inf",   32'h0000_0000, 32'h7F80_0000, 32'h0000_0000, ONE, ONE, 8'h00, 0, 0, 0);
        vec("R6 -inf/2",  32'hFF80_0000, 32'h4000_0000, 32'hFF80_0000, ONE, ONE, 8'h00, 0, 0, 0);
        vec("R6 inf/-1",  32'h7F80_0000, 32'hBF80_0000, 32'hFF80_0000, ONE, ONE, 8'h00, 0, 0, 0);
    endtask

    task automatic t_windows;
        vec("R7 plain 6/2",      32'h40C0_0000, 32'h4000_0000, 32'h40C0_0000, 32'h4000_0000, 0, 8'h00, 1, 0, 0);
        vec("R7 plain -6/2",     32'hC0C0_0000, 32'h4000_0000, 32'hC0C0_0000, 32'h4000_0000, 0, 8'h00, 1, 0, 0);
        vec("R8 low window",     32'h0500_0000, 32'h6400_0000, 32'h2500_0000, 32'h4400_0000, 0, 8'h80, 1, 0, 0);
        vec("R8 low neg",        32'h8500_0000, 32'h6400_0000, 32'hA500_0000, 32'h4400_0000, 0, 8'h80, 1, 0, 0);
        vec("R8 low edge",       32'h0C00_0000, 32'h4000_0000, 32'h2C00_0000, 32'h2000_0000, 0, 8'h80, 1, 0, 0);
        vec("R10 past low edge", 32'h0C80_0000, 32'h4000_0000, 32'h2C80_0000, 32'h6000_0000, 0, 8'h00, 1, 0, 0);
        vec("R10 ne=26 none",    32'h0D00_0000, ONE,           32'h0D00_0000, ONE,           0, 8'h00, 1, 0, 0);
        vec("R9 high edge out",  32'h6400_0000, 32'h3080_0000, 32'h6400_0000, 32'h3080_0000, 0, 8'h00, 1, 0, 0);
        vec("R9 high window",    32'h6480_0000, 32'h3080_0000, 32'h5480_0000, 32'h4080_0000, 0, 8'h40, 1, 0, 0);
        vec("R9 high big",       32'h7D00_0000, 32'h3200_0000, 32'h6D00_0000, 32'h4200_0000, 0, 8'h40, 1, 0, 0);
        vec("R11 tiny den",      32'h3200_0000, 32'h0080_0000, 32'h4200_0000, 32'h1080_0000, 0, 8'h00, 1, 0, 0);
        vec("R11 huge den",      32'h7F00_0000, 32'h7E80_0000, 32'h6F00_0000, 32'h6E80_0000, 0, 8'h00, 1, 0, 0);
        vec("R10 small num first", 32'h0A00_0000, 32'h0080_0000, 32'h2A00_0000, 32'h2080_0000, 0, 8'h00, 1, 0, 0);
    endtask

    task automatic t_subnormal;
        vec("R12 sub num low",   32'h0000_0001, ONE,           32'h1500_0000, 32'h1F80_0000, 0, 8'h80, 1, 0, 0);
        vec("R12 sub num frac",  32'h0030_0000, 32'h7F00_0000, 32'h1FC0_0000, 32'h5F00_0000, 0, 8'h80, 1, 0, 0);
        vec("R12 sub den tiny",  32'h3200_0000, 32'h0040_0000, 32'h4200_0000, 32'h1000_0000, 0, 8'h00, 1, 0, 0);
        vec("R12 neg sub den",   32'h3200_0000, 32'h8040_0000, 32'h4200_0000, 32'h9000_0000, 0, 8'h00, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_nan();
        t_invalid_ops();
        t_divzero();
        t_zero_inf();
        t_windows();
        t_subnormal();   // R13 exclusivity covered by every vector's pulse pair
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end
endmodule